// File: doc/BRIEF.md
# Frequency-Locked Sample Strobe Generator

This block produces ADC conversion strobes whose spacing is servoed so that one period of an incoming AC waveform holds exactly 128 strobes. An external comparator delivers one synchronous single-cycle pulse per waveform period. The pulse can be taken at any fixed level of the waveform and does not need to be a zero crossing. A reloading timer issues a strobe every `period + 1` clocks. At each frame boundary the number of strobes since the previous boundary is compared with the target, and the period register moves by one tick towards lock. The register is kept inside a programmable window, so a lost or noisy sync cannot drive it to an extreme.

The block also does the front end of the capture. Each strobe has a sample index. The first 128 strobes of a frame write the incoming sample, minus a running DC offset, into the buffer slot named by that index. Later strobes are still counted but write nothing. The DC offset moves by one step whenever the downstream transform reports the sign of its zero bin. A lock flag reports a stable servo. A report pulse marks each group of 32 frames, the point at which averaged results are due. In oversampled mode a frame spans eight waveform periods, so the strobe runs eight times slower for the same 128 samples.

Top module: `sync_locked_sampler`

## Requirements
- R1: After a frame boundary, `strobe_o` pulses on the clock cycles that lie a whole positive multiple of `period_o + 1` cycles after it. It never pulses in a boundary cycle.
- R2: With `oversample_i` low, every `sync_i` pulse is a frame boundary. With it high, only every 8th pulse is a boundary, and the sync pulses in between change neither the period nor the strobe timing.
- R3: At a boundary the strobe count of the ending frame sets the next `period_o`, visible one cycle later: more than 128 strobes adds 1, fewer subtracts 1, exactly 128 leaves it unchanged.
- R4: A step never takes `period_o` above `period_max_i` or below `period_min_i`. A period outside the window is moved to the nearer bound at the next boundary.
- R5: One cycle after each strobe whose index is below 128, `wr_en_o` is high, `wr_idx_o` is the index and `wr_data_o` equals `sample_i` at the strobe minus `offset_o` at the strobe (signed, one bit wider). Strobes with index 128 or more produce no write but still count towards R3.
- R6: The sample index is 0 for the first strobe after a boundary and rises by one on each later strobe.
- R7: One cycle after `bin0_valid_i`, `offset_o` has risen by 1 if `bin0_i` (signed) is positive, fallen by 1 if it is negative, and is unchanged if it is zero. It changes at no other time. It resets to 0.
- R8: `lock_o` is high from the cycle after the 4th consecutive boundary whose frame held exactly 128 strobes. It goes low one cycle after a boundary whose frame held any other count.
- R9: `report_o` is a one-cycle pulse in the cycle after every 32nd frame boundary counted from reset.
- R10: During reset `strobe_o`, `wr_en_o`, `lock_o` and `report_o` are low, `offset_o` is 0 and `period_o` is `PERIOD_INIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Synchronous single-cycle pulse, one per waveform period |
| oversample_i | input | 1 | 1: frame spans 8 sync periods |
| period_min_i | input | PER_W | Lower bound of the period register |
| period_max_i | input | PER_W | Upper bound of the period register |
| sample_i | input | SAMP_W | Signed ADC result, taken in the strobe cycle |
| bin0_valid_i | input | 1 | Zero-bin sign report is valid |
| bin0_i | input | BIN_W | Signed real part of the zero bin |
| strobe_o | output | 1 | Conversion strobe |
| wr_en_o | output | 1 | Capture buffer write enable |
| wr_idx_o | output | IDX_W | Capture buffer index |
| wr_data_o | output | SAMP_W+1 | Offset-corrected signed sample |
| period_o | output | PER_W | Current timer period (strobe spacing minus one) |
| offset_o | output | SAMP_W | Signed running DC offset |
| lock_o | output | 1 | Servo locked |
| report_o | output | 1 | Pulse every 32 frames |

## Verification
Sync spacings are chosen so that one settles the period on an exact lock (1541 clocks), and another has no period that gives 128, so the servo must dither between two values and one of them yields 129 strobes. That second spacing separates the index running past the buffer from a write. The same spacings are run against a narrowed window from each side, which shows whether a step is clamped or the register is snapped back inside. Oversampled mode is run with sync pulses one eighth as far apart, which shows whether the intermediate pulses are ignored. Zero-bin reports cycle through positive, negative and zero values while samples sweep the full signed range. The strobe, write, period, offset, lock and report outputs are compared with an arithmetic model on every cycle.

// File: rtl/fls_pkg.sv
package fls_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/fls_frame_seq.sv
module fls_frame_seq #(
  parameter int OVS_RATIO  = 8,
  parameter int AVG_FRAMES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic oversample_i,
  output logic frame_o,
  output logic report_o
);
  localparam int SUB_W = $clog2(OVS_RATIO);
  localparam int AVG_W = $clog2(AVG_FRAMES);

  logic [SUB_W-1:0] sub_q;
  logic [AVG_W-1:0] avg_q;
  logic             report_q;
  logic             last_sub;

  assign last_sub = (sub_q == SUB_W'(OVS_RATIO - 1));
  assign frame_o  = sync_i && (!oversample_i || last_sub);
  assign report_o = report_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q    <= '0;
      avg_q    <= '0;
      report_q <= 1'b0;
    end else begin
      report_q <= 1'b0;
      if (!oversample_i)   sub_q <= '0;
      else if (sync_i)     sub_q <= last_sub ? '0 : sub_q + 1'b1;
      if (frame_o) begin
        if (avg_q == AVG_W'(AVG_FRAMES - 1)) begin
          avg_q    <= '0;
          report_q <= 1'b1;
        end else begin
          avg_q <= avg_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fls_strobe_timer.sv
module fls_strobe_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic [PER_W-1:0] period_i,
  output logic             strobe_o
);
  logic [PER_W-1:0] tmr_q;
  logic             at_end;

  // >= guards against a period that shrank below the running count
  assign at_end   = (tmr_q >= period_i);
  assign strobe_o = at_end && !frame_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tmr_q <= '0;
    else if (frame_i || at_end) tmr_q <= '0;
    else                        tmr_q <= tmr_q + 1'b1;
  end
endmodule

// File: rtl/fls_period_servo.sv
module fls_period_servo
  import fls_pkg::*;
#(
  parameter int PER_W       = 16,
  parameter int CNT_W       = 9,
  parameter int TARGET      = 128,
  parameter int LOCK_RUN    = 4,
  parameter int PERIOD_INIT = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [PER_W-1:0] period_min_i,
  input  logic [PER_W-1:0] period_max_i,
  output logic [PER_W-1:0] period_o,
  output logic             lock_o
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);

  logic [PER_W-1:0] period_q, period_d;
  logic [RUN_W-1:0] run_q;
  step_e            dir;

  always_comb begin
    if (count_i > CNT_W'(TARGET))      dir = STEP_UP;
    else if (count_i < CNT_W'(TARGET)) dir = STEP_DOWN;
    else                               dir = STEP_HOLD;
  end

  always_comb begin
    period_d = period_q;
    case (dir)
      STEP_UP:   if (period_q < period_max_i) period_d = period_q + 1'b1;
      STEP_DOWN: if (period_q > period_min_i) period_d = period_q - 1'b1;
      default:   period_d = period_q;
    endcase
    // snap into window if bounds moved
    if (period_d > period_max_i) period_d = period_max_i;
    if (period_d < period_min_i) period_d = period_min_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= PER_W'(PERIOD_INIT);
      run_q    <= '0;
    end else if (frame_i) begin
      period_q <= period_d;
      if (dir != STEP_HOLD)                 run_q <= '0;
      else if (run_q != RUN_W'(LOCK_RUN))   run_q <= run_q + 1'b1;
    end
  end

  assign period_o = period_q;
  assign lock_o   = (run_q == RUN_W'(LOCK_RUN));
endmodule

// File: rtl/fls_capture_path.sv
module fls_capture_path #(
  parameter int TARGET = 128,
  parameter int CNT_W  = 9,
  parameter int IDX_W  = 7,
  parameter int SAMP_W = 12,
  parameter int BIN_W  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     frame_i,
  input  logic                     strobe_i,
  input  logic signed [SAMP_W-1:0] sample_i,
  input  logic                     bin0_valid_i,
  input  logic signed [BIN_W-1:0]  bin0_i,
  output logic [CNT_W-1:0]         count_o,
  output logic                     wr_en_o,
  output logic [IDX_W-1:0]         wr_idx_o,
  output logic signed [SAMP_W:0]   wr_data_o,
  output logic signed [SAMP_W-1:0] offset_o
);
  localparam logic [CNT_W-1:0]         CNT_MAX = '1;
  localparam logic signed [SAMP_W-1:0] OFS_MAX = {1'b0, {(SAMP_W-1){1'b1}}};
  localparam logic signed [SAMP_W-1:0] OFS_MIN = {1'b1, {(SAMP_W-1){1'b0}}};

  logic [CNT_W-1:0]         cnt_q;
  logic                     wr_en_q;
  logic [IDX_W-1:0]         wr_idx_q;
  logic signed [SAMP_W:0]   wr_data_q, diff;
  logic signed [SAMP_W-1:0] ofs_q;
  logic                     bin_pos, bin_neg;

  assign diff    = {sample_i[SAMP_W-1], sample_i} - {ofs_q[SAMP_W-1], ofs_q};
  assign bin_neg = bin0_i[BIN_W-1];
  assign bin_pos = !bin_neg && (bin0_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= strobe_i && (cnt_q < CNT_W'(TARGET));
      if (strobe_i) begin
        wr_idx_q  <= cnt_q[IDX_W-1:0];
        wr_data_q <= diff;
      end
      if (frame_i)                            cnt_q <= '0;
      else if (strobe_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ofs_q <= '0;
    else if (bin0_valid_i) begin
      if (bin_pos && ofs_q != OFS_MAX)      ofs_q <= ofs_q + 1'b1;
      else if (bin_neg && ofs_q != OFS_MIN) ofs_q <= ofs_q - 1'b1;
    end
  end

  assign count_o   = cnt_q;
  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = wr_data_q;
  assign offset_o  = ofs_q;
endmodule

// File: rtl/sync_locked_sampler.sv
module sync_locked_sampler #(
  parameter int PER_W       = 16,
  parameter int TARGET      = 128,
  parameter int SAMP_W      = 12,
  parameter int BIN_W       = 16,
  parameter int OVS_RATIO   = 8,
  parameter int AVG_FRAMES  = 32,
  parameter int LOCK_RUN    = 4,
  parameter int PERIOD_INIT = 100,
  localparam int IDX_W      = $clog2(TARGET),
  localparam int CNT_W      = IDX_W + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sync_i,
  input  logic                     oversample_i,
  input  logic [PER_W-1:0]         period_min_i,
  input  logic [PER_W-1:0]         period_max_i,
  input  logic signed [SAMP_W-1:0] sample_i,
  input  logic                     bin0_valid_i,
  input  logic signed [BIN_W-1:0]  bin0_i,
  output logic                     strobe_o,
  output logic                     wr_en_o,
  output logic [IDX_W-1:0]         wr_idx_o,
  output logic signed [SAMP_W:0]   wr_data_o,
  output logic [PER_W-1:0]         period_o,
  output logic signed [SAMP_W-1:0] offset_o,
  output logic                     lock_o,
  output logic                     report_o
);
  logic             frame_w;
  logic [CNT_W-1:0] count_w;

  fls_frame_seq #(
    .OVS_RATIO (OVS_RATIO),
    .AVG_FRAMES(AVG_FRAMES)
  ) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_i      (sync_i),
    .oversample_i(oversample_i),
    .frame_o     (frame_w),
    .report_o    (report_o)
  );

  fls_strobe_timer #(.PER_W(PER_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_i (frame_w),
    .period_i(period_o),
    .strobe_o(strobe_o)
  );

  fls_period_servo #(
    .PER_W      (PER_W),
    .CNT_W      (CNT_W),
    .TARGET     (TARGET),
    .LOCK_RUN   (LOCK_RUN),
    .PERIOD_INIT(PERIOD_INIT)
  ) u_servo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_i     (frame_w),
    .count_i     (count_w),
    .period_min_i(period_min_i),
    .period_max_i(period_max_i),
    .period_o    (period_o),
    .lock_o      (lock_o)
  );

  fls_capture_path #(
    .TARGET(TARGET),
    .CNT_W (CNT_W),
    .IDX_W (IDX_W),
    .SAMP_W(SAMP_W),
    .BIN_W (BIN_W)
  ) u_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_i     (frame_w),
    .strobe_i    (strobe_o),
    .sample_i    (sample_i),
    .bin0_valid_i(bin0_valid_i),
    .bin0_i      (bin0_i),
    .count_o     (count_w),
    .wr_en_o     (wr_en_o),
    .wr_idx_o    (wr_idx_o),
    .wr_data_o   (wr_data_o),
    .offset_o    (offset_o)
  );
endmodule

// File: rtl/sync_locked_sampler_chk.sv
module sync_locked_sampler_chk #(
  parameter int PER_W  = 16,
  parameter int SAMP_W = 12
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     frame_w,
  input logic                     strobe_o,
  input logic                     wr_en_o,
  input logic [PER_W-1:0]         period_o,
  input logic [PER_W-1:0]         period_min_i,
  input logic [PER_W-1:0]         period_max_i,
  input logic                     bin0_valid_i,
  input logic signed [SAMP_W-1:0] offset_o,
  input logic                     lock_o,
  input logic                     report_o
);
  a_r3_period_only_at_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_w |=> $stable(period_o));

  a_r4_period_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_w && (period_min_i <= period_max_i) |=>
      (period_o >= $past(period_min_i)) && (period_o <= $past(period_max_i)));

  a_r5_write_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(strobe_o));

  a_r7_offset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bin0_valid_i |=> $stable(offset_o));

  a_r8_lock_only_at_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_w |=> $stable(lock_o));

  a_r9_report_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    report_o |-> $past(frame_w));
endmodule

bind sync_locked_sampler sync_locked_sampler_chk #(
  .PER_W (PER_W),
  .SAMP_W(SAMP_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_w     (frame_w),
  .strobe_o    (strobe_o),
  .wr_en_o     (wr_en_o),
  .period_o    (period_o),
  .period_min_i(period_min_i),
  .period_max_i(period_max_i),
  .bin0_valid_i(bin0_valid_i),
  .offset_o    (offset_o),
  .lock_o      (lock_o),
  .report_o    (report_o)
);

// File: tb/sync_locked_sampler_tb.sv
module sync_locked_sampler_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PINIT      = 14;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               sync_i = 1'b0;
  logic               oversample_i = 1'b0;
  logic [15:0]        period_min_i = 16'd2;
  logic [15:0]        period_max_i = 16'd1000;
  logic signed [11:0] sample_i = '0;
  logic               bin0_valid_i = 1'b0;
  logic signed [15:0] bin0_i = '0;
  logic               strobe_o, wr_en_o, lock_o, report_o;
  logic [6:0]         wr_idx_o;
  logic signed [12:0] wr_data_o;
  logic [15:0]        period_o;
  logic signed [11:0] offset_o;

  sync_locked_sampler #(.PERIOD_INIT(PINIT)) u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int  n_chk = 0, n_fail = 0;
  int  cyc = 0;
  int  p_m = PINIT, run_m = 0, fr_m = 0, sub_m = 0, ofs_m = 0;
  int  c_m = 0, len = 0, e_idx = 0, e_data = 0;
  int  min_v = 2, max_v = 1000;
  bit  ovs = 0, pend_wr = 0, rep_m = 0, done = 0;
  string ptag = "R3";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic step(input bit s);
    int k, bval, smp;
    bit bv, is_frame, exp_str;
    @(negedge clk_i);
    cyc++;
    bv   = (cyc % 500) == 250;
    k    = cyc / 500;
    bval = (k % 3 == 0) ? 100 : ((k % 3 == 1) ? -50 : 0);
    smp  = ((cyc * 37 + 5) % 4096) - 2048;
    sync_i = s; oversample_i = ovs; bin0_valid_i = bv;
    bin0_i = 16'(bval); sample_i = 12'(smp);
    period_min_i = 16'(min_v); period_max_i = 16'(max_v);
    #1;
    // registered outputs from the previous cycle
    if (pend_wr) begin
      chk(wr_en_o == 1'b1, "R5 write missing", int'(wr_en_o), 1);
      chk(int'(wr_idx_o) == e_idx, "R6 write index", int'(wr_idx_o), e_idx);
      chk(int'(wr_data_o) == e_data, "R5 write data", int'(wr_data_o), e_data);
    end else begin
      chk(wr_en_o == 1'b0, "R5 spurious write", int'(wr_en_o), 0);
    end
    chk(int'(period_o) == p_m, ovs ? "R2 period" : ptag, int'(period_o), p_m);
    chk(int'(offset_o) == ofs_m, "R7 offset", int'(offset_o), ofs_m);
    chk(lock_o == (run_m == 4), "R8 lock", int'(lock_o), int'(run_m == 4));
    chk(report_o == rep_m, "R9 report", int'(report_o), int'(rep_m));
    // current cycle
    pend_wr  = 0;
    rep_m    = 0;
    is_frame = s && (!ovs || sub_m == 7);
    if (!ovs) sub_m = 0;
    else if (s) sub_m = (sub_m == 7) ? 0 : sub_m + 1;
    exp_str = !is_frame && len > 0 && (len % (p_m + 1)) == 0;
    chk(strobe_o == exp_str, "R1 strobe", int'(strobe_o), int'(exp_str));
    if (exp_str) begin
      if (c_m < 128) begin
        pend_wr = 1; e_idx = c_m; e_data = smp - ofs_m;
      end
      c_m++;
    end
    if (bv) begin
      if (bval > 0 && ofs_m < 2047) ofs_m++;
      else if (bval < 0 && ofs_m > -2048) ofs_m--;
    end
    if (is_frame) begin
      if (c_m > 128 && p_m < max_v) p_m++;
      else if (c_m < 128 && p_m > min_v) p_m--;
      if (p_m > max_v) p_m = max_v;
      if (p_m < min_v) p_m = min_v;
      if (c_m != 128) run_m = 0;
      else if (run_m < 4) run_m++;
      if (fr_m == 31) begin fr_m = 0; rep_m = 1; end
      else fr_m++;
      c_m = 0;
      len = 1;
    end else begin
      len++;
    end
  endtask

  task automatic run_syncs(input int t, input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b1);
      for (int j = 1; j < t; j++) step(1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    // R10 reset state
    chk(strobe_o == 1'b0, "R10 strobe", int'(strobe_o), 0);
    chk(wr_en_o == 1'b0, "R10 wr_en", int'(wr_en_o), 0);
    chk(lock_o == 1'b0, "R10 lock", int'(lock_o), 0);
    chk(report_o == 1'b0, "R10 report", int'(report_o), 0);
    chk(offset_o == 0, "R10 offset", int'(offset_o), 0);
    chk(int'(period_o) == PINIT, "R10 period", int'(period_o), PINIT);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // exact lock: 1541-clock sync -> period 11, 128 strobes (R3, R8)
    run_syncs(1541, 12);
    // no exact period: dithers 9/10, 129-strobe frames (R5, R6)
    run_syncs(1300, 10);
    // narrowed window from below then above (R4)
    ptag = "R4 period"; min_v = 10;
    run_syncs(1300, 6);
    min_v = 2; max_v = 8;
    run_syncs(1300, 4);
    // oversampled: 8 syncs of 193 per frame (R2)
    ptag = "R3 period"; min_v = 2; max_v = 1000; ovs = 1;
    run_syncs(193, 80);
    step(1'b0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired at cyc=%0d actual=0 expected=1", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule